// File: doc/BRIEF.md
# Level Interrupt Aggregator

This peripheral gathers a vector of level-sensitive interrupt lines and reduces them to a single request line for a parent interrupt controller. Each source line first passes through a two-flop synchronizer. It is then gated by its own enable bit, which gives a pending bit. The request output is asserted whenever any pending bit is set.

Software reaches the block over a simple 32-bit register bus. One read-only word shows every pending source, with bit n standing for source n. Enables are never written directly. One write-only register sets the enable bits selected by ones in the data. A second clears the enable bits selected by ones. A third turns off every source at once, whatever data is written. Pending bits have no storage of their own, so reading them clears nothing. A source stops being pending as soon as its line drops or its enable is removed. Software decides service order, normally starting from the highest-numbered pending bit, so the block contains no priority logic.

Top module: `irqagg_top`

## Requirements
- R1: After a synchronous active-low reset, every enable bit is 0, `irq_out` is low and `bus_rdata` is 0.
- R2: A read (`bus_en`=1, `bus_we`=0) of byte offset 0x04 returns the pending word on `bus_rdata` in the cycle after the access. Bit n is source n.
- R3: A write of any data to offset 0x08 clears all enable bits.
- R4: A write to offset 0x0C clears the enable bit of each source whose data bit is 1. Sources whose data bit is 0 keep their enable bit.
- R5: A write to offset 0x10 sets the enable bit of each source whose data bit is 1. Sources whose data bit is 0 keep their enable bit.
- R6: Pending bit n equals the synchronized level of source n ANDed with its enable bit. Nothing is latched, and reading the pending word changes nothing.
- R7: `irq_out` is the OR of all pending bits.
- R8: A change on `irq_src` reaches the pending word and `irq_out` after exactly two rising clock edges and not after one.
- R9: Reads of offsets 0x08, 0x0C, 0x10 and of any unmapped offset return 0. Writes to 0x04 or to unmapped offsets leave every enable bit unchanged. `bus_rdata` is 0 in any cycle that follows a cycle with no read access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | NUM_SRC (32) | Asynchronous level interrupt sources |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq_out | output | 1 | Combined interrupt request to the parent controller |

## Verification
The bench builds the block with its defaults: 32 sources on a 32-bit data path, 8-bit byte addressing and two synchronizer stages. Because the source count equals the data width, every bit of every register is reachable. All-ones and all-zeros masks, as well as the highest and lowest source bits, can be driven directly. The two-stage setting fixes the input-to-output latency at two edges, which the bench probes one edge at a time. Random mixes of set, clear, clear-all and stray writes, interleaved with random source levels, are compared against a bench model of the enable mask.

// File: rtl/irqagg_pkg.sv
// irqagg_pkg: register offsets and shared types for the interrupt aggregator.
// Assumes byte addressing with word-aligned 32-bit registers.
package irqagg_pkg;

    localparam int unsigned OFS_PENDING  = 32'h04;
    localparam int unsigned OFS_MASK_ALL = 32'h08;
    localparam int unsigned OFS_CLR_EN   = 32'h0C;
    localparam int unsigned OFS_SET_EN   = 32'h10;

    // Which register an access addresses.
    typedef enum logic [2:0] {
        REG_NONE,
        REG_PENDING,
        REG_MASK_ALL,
        REG_CLR_EN,
        REG_SET_EN
    } reg_sel_e;

    // Write strobes toward the enable mask, at most one active.
    typedef struct packed {
        logic mask_all;
        logic clr_en;
        logic set_en;
    } wr_strobe_t;

endpackage

// File: rtl/irqagg_sync.sv
// irqagg_sync: multi-stage flop synchronizer for a vector of level inputs.
// Assumes each bit is an independent slow level; no bus coherency is implied.
module irqagg_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Later stages shift the sampled value along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[gi] <= '0;
                else        stage_q[gi] <= stage_q[gi-1];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/irqagg_decode.sv
// irqagg_decode: turns a bus access into a register select and write strobes.
// Assumes a single-cycle access strobe; reads of write-only registers decode as no read.
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    output reg_sel_e          reg_sel,
    output wr_strobe_t        wstb,
    output logic              rd_pending
);

    // Map the address onto one register, or none.
    always_comb begin
        if      (acc_addr == ADDR_W'(OFS_PENDING))  reg_sel = REG_PENDING;
        else if (acc_addr == ADDR_W'(OFS_MASK_ALL)) reg_sel = REG_MASK_ALL;
        else if (acc_addr == ADDR_W'(OFS_CLR_EN))   reg_sel = REG_CLR_EN;
        else if (acc_addr == ADDR_W'(OFS_SET_EN))   reg_sel = REG_SET_EN;
        else                                        reg_sel = REG_NONE;
    end

    // Qualify the select with the access type.
    always_comb begin
        wstb.mask_all = acc_en && acc_we && (reg_sel == REG_MASK_ALL);
        wstb.clr_en   = acc_en && acc_we && (reg_sel == REG_CLR_EN);
        wstb.set_en   = acc_en && acc_we && (reg_sel == REG_SET_EN);
        rd_pending    = acc_en && !acc_we && (reg_sel == REG_PENDING);
    end

endmodule

// File: rtl/irqagg_mask.sv
// irqagg_mask: per-source enable register with bitwise set, bitwise clear and clear-all.
// Assumes the decoder raises at most one strobe per cycle.
module irqagg_mask
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  wr_strobe_t         wstb,
    input  logic [NUM_SRC-1:0] wr_bits,
    output logic [NUM_SRC-1:0] enable
);

    logic [NUM_SRC-1:0] en_q;

    // Update the enable bits from the write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)             en_q <= '0;
        else if (wstb.mask_all) en_q <= '0;
        else if (wstb.clr_en)   en_q <= en_q & ~wr_bits;
        else if (wstb.set_en)   en_q <= en_q | wr_bits;
    end

    assign enable = en_q;

    // R3: clear-all leaves no source enabled.
    a_r3_mask_all_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wstb.mask_all |=> (en_q == '0));

    // R4: selected bits drop, the rest hold.
    a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wstb.clr_en |=> ((en_q & $past(wr_bits)) == '0) &&
                        ((en_q & ~$past(wr_bits)) == ($past(en_q) & ~$past(wr_bits))));

    // R5: selected bits rise, the rest hold.
    a_r5_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wstb.set_en |=> ((en_q & $past(wr_bits)) == $past(wr_bits)) &&
                        ((en_q & ~$past(wr_bits)) == ($past(en_q) & ~$past(wr_bits))));

    // R9: without a mask write the enables do not move.
    a_r9_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wstb == '0) |=> $stable(en_q));

endmodule

// File: rtl/irqagg_readmux.sv
// irqagg_readmux: registered read-data path; returns the pending word or zero.
// Assumes only the pending register is readable.
module irqagg_readmux #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_pending,
    input  logic [NUM_SRC-1:0] pending,
    output logic [DATA_W-1:0]  rdata
);

    logic [DATA_W-1:0] rdata_q;

    // Capture the pending word on a read, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          rdata_q <= '0;
        else if (rd_pending) rdata_q <= DATA_W'(pending);
        else                 rdata_q <= '0;
    end

    assign rdata = rdata_q;

    // R9: a cycle without a pending read leaves the read bus at zero.
    a_r9_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_pending |=> (rdata_q == '0));

endmodule

// File: rtl/irqagg_top.sv
// irqagg_top: level interrupt aggregator with a small register bus.
// Sources are synchronized, gated by enables and ORed into one request line.
// Assumes NUM_SRC <= DATA_W and single-cycle register accesses.
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_out
);

    reg_sel_e           reg_sel;
    wr_strobe_t         wstb;
    logic               rd_pending;
    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] enable;
    logic [NUM_SRC-1:0] pending;

    irqagg_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_src),
        .sync_out (src_sync)
    );

    irqagg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .acc_en     (bus_en),
        .acc_we     (bus_we),
        .acc_addr   (bus_addr),
        .reg_sel    (reg_sel),
        .wstb       (wstb),
        .rd_pending (rd_pending)
    );

    irqagg_mask #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wstb    (wstb),
        .wr_bits (bus_wdata[NUM_SRC-1:0]),
        .enable  (enable)
    );

    // Gate each synchronized level with its enable bit.
    always_comb pending = src_sync & enable;

    // Combine every pending source into the single request.
    always_comb irq_out = |pending;

    irqagg_readmux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_readmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_pending (rd_pending),
        .pending    (pending),
        .rdata      (bus_rdata)
    );

    // Cycles since reset, saturating, so the latency check looks no further back than reset.
    logic [1:0] since_rst_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst_q <= '0;
        else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
    end

    generate
        if (SYNC_STAGES == 2) begin : g_lat_chk
            // R8: synchronized levels equal the raw inputs of two edges earlier.
            a_r8_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst_q >= 2'd2) |-> (src_sync == $past(irq_src, 2)));
        end
    endgenerate

    // R2: a pending read returns the word seen at the access.
    a_r2_read_pending: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pending |=> (bus_rdata == DATA_W'($past(src_sync) & $past(enable))));

endmodule

// File: tb/irqagg_top_test.sv
module irqagg_top_test;

    localparam int unsigned N = 32;
    localparam int unsigned AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_src = '0;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_out;

    int total = 0;
    int bad = 0;
    logic [N-1:0] m_en = '0;

    always #4 clk = ~clk;

    irqagg_top uut (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_en(bus_en),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic logic [N-1:0] exp_pending(input logic [N-1:0] lvl, input logic [N-1:0] en);
        return lvl & en;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        if (a == 8'h08) m_en = '0;
        else if (a == 8'h0C) m_en = m_en & ~d;
        else if (a == 8'h10) m_en = m_en | d;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic check_pending(input string req);
        logic [31:0] rd;
        bus_read(8'h04, rd);
        check(req, rd, exp_pending(irq_src, m_en));
        check("R7", {31'd0, irq_out}, {31'd0, |exp_pending(irq_src, m_en)});
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {31'd0, irq_out}, 32'd0);
        check("R1", bus_rdata, 32'd0);
        irq_src = '1;
        settle();
        check("R1", {31'd0, irq_out}, 32'd0);
        check_pending("R1");

        // R5 set enables, top and bottom bits
        bus_write(8'h10, 32'h8000_0001);
        check_pending("R5");
        bus_write(8'h10, 32'h0000_ff00);
        check_pending("R5");
        // R4 clear selected bits only
        bus_write(8'h0C, 32'h0000_0f01);
        check_pending("R4");
        // R9 writes to pending and unmapped offsets ignored
        bus_write(8'h04, 32'hffff_ffff);
        check_pending("R9");
        bus_write(8'h20, 32'hffff_ffff);
        check_pending("R9");
        // R9 write-only and unmapped reads are zero
        bus_read(8'h08, rd); check("R9", rd, 32'd0);
        bus_read(8'h0C, rd); check("R9", rd, 32'd0);
        bus_read(8'h10, rd); check("R9", rd, 32'd0);
        bus_read(8'h14, rd); check("R9", rd, 32'd0);
        @(negedge clk); check("R9", bus_rdata, 32'd0);
        // R6 level: drop input clears pending; reading twice is stable
        irq_src = 32'h8000_0000;
        settle();
        check_pending("R6");
        check_pending("R6");
        irq_src = '0;
        settle();
        check_pending("R6");
        // R3 clear-all
        bus_write(8'h10, 32'hffff_ffff);
        irq_src = '1;
        settle();
        check_pending("R3");
        bus_write(8'h08, 32'h0000_0000);
        check_pending("R3");
        check("R3", {31'd0, irq_out}, 32'd0);

        // R8 latency: enable all, then raise one source
        bus_write(8'h10, 32'hffff_ffff);
        irq_src = '0;
        settle();
        check("R8", {31'd0, irq_out}, 32'd0);
        @(negedge clk); irq_src = 32'h0000_0010;
        @(negedge clk); check("R8", {31'd0, irq_out}, 32'd0);
        @(negedge clk); check("R8", {31'd0, irq_out}, 32'd1);
        @(negedge clk); irq_src = '0;
        @(negedge clk); check("R8", {31'd0, irq_out}, 32'd1);
        @(negedge clk); check("R8", {31'd0, irq_out}, 32'd0);

        // Random mix checked against the model (R2, R4, R5, R6, R9)
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom % 8;
            case (op)
                0, 1: bus_write(8'h10, $urandom);
                2, 3: bus_write(8'h0C, $urandom);
                4:    if (($urandom % 4) == 0) bus_write(8'h08, $urandom);
                5:    bus_write(8'((($urandom % 16) + 5) * 4), $urandom);
                default: irq_src = $urandom;
            endcase
            settle();
            check_pending("R2");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule